// File: doc/BRIEF.md
# Clock Frequency Change Sequencer

This block runs the handshake that moves the system clock between full speed, half speed and one-thirty-second speed. Software first loads five delay registers. It then writes a one-hot speed code to a control register. A valid write freezes the system, and the block waits for the freeze to be acknowledged. It then pulls the change line for the chosen speed low, puts the PLL into bypass, takes it out of bypass, releases the change line and finally lifts the freeze. Each of these moves waits for its own programmed delay.

The block's clock is the half-rate sequencer clock, so every delay counts cycles of that clock. Software leaves the code written for a while and then clears it, which arms the block for the next change. The block does not program the CPUs or the PLL. A status register tells software when a sequence is still running.

Top module: `clk_freq_seq`

## Requirements
- R1: After reset, freeze_l is 1, clk_change_l is 3'b111, pll_bypass is 0, and every register reads 0.
- R2: Speed code bit 0 selects change line 0 (full speed), bit 1 selects line 1 (half speed) and bit 5 selects line 2 (1/32 speed). During the change window only that line is low, and it does not switch to another line.
- R3: A write to the code register (address 0) starts a sequence only if two things hold. Exactly one of bits 0, 1 and 5 is set in the written value, and that bit was 0 in the stored code. Writing zero or several of these bits starts nothing. Bits 2, 3, 4, 6 and 7 are dropped and read back as 0.
- R4: Writing the same one-hot code again without clearing it first starts nothing.
- R5: freeze_l falls on the clock edge that captures a starting write. It stays low until freeze_ack is sampled high, and as long as the block is busy.
- R6: The selected change line goes low exactly CHG+1 cycles after the edge that samples freeze_ack high.
- R7: pll_bypass rises exactly BYP+1 cycles after the change line goes low.
- R8: pll_bypass falls exactly UNBYP+1 cycles after it rose.
- R9: The change line returns high exactly UNCHG+1 cycles after pll_bypass fell.
- R10: freeze_l returns high exactly SETTLE+1 cycles after the change line rose. The busy bit clears on the same edge.
- R11: While busy, the status register (address 1, bit 0) reads 1, and code writes start nothing and do not alter the running sequence.
- R12: Register map: address 2 holds CHG (8 bits), address 3 BYP (16 bits), address 4 UNBYP (8 bits), address 5 UNCHG (8 bits) and address 6 SETTLE (32 bits). Bits written above a field's width are dropped, and a read returns the field zero-extended.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Half-rate sequencer clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational on reg_addr) |
| freeze_ack | input | 1 | Freeze acknowledge from the system |
| freeze_l | output | 1 | Freeze request, active low |
| clk_change_l | output | 3 | Per-speed change lines, active low |
| pll_bypass | output | 1 | PLL bypass request, active high |

## Verification
The bench times each output edge against the edge before it, using delays of zero, small values and a large settle count. A counter that is off by one, or one that reloads from the wrong register, therefore shows up as an event on the wrong cycle. Some writes must not start a sequence: multi-bit codes, reserved-only codes, a repeated code with no clear in between, and writes made while busy. A design with a loose trigger rule would freeze the system on one of these, or would switch change lines in the middle of a sequence. The bench also changes speed directly from one code to another, and it holds back the acknowledge. An edge detector that looks at the whole value, rather than at each bit, fails the direct change. A design that does not wait for the acknowledge moves its change line early.

// File: rtl/cfs_pkg.sv
package cfs_pkg;
  localparam int ADDR_W = 4;
  localparam int DATA_W = 32;
  localparam int CODE_W = 8;
  localparam int NLINE  = 3;

  localparam int FULL_BIT = 0;
  localparam int HALF_BIT = 1;
  localparam int SLOW_BIT = 5;

  localparam int LINE_BIT [NLINE] = '{FULL_BIT, HALF_BIT, SLOW_BIT};

  localparam logic [CODE_W-1:0] CODE_MASK =
    CODE_W'((1 << FULL_BIT) | (1 << HALF_BIT) | (1 << SLOW_BIT));

  localparam logic [ADDR_W-1:0] A_CODE   = 4'd0;
  localparam logic [ADDR_W-1:0] A_STAT   = 4'd1;
  localparam logic [ADDR_W-1:0] A_CHG    = 4'd2;
  localparam logic [ADDR_W-1:0] A_BYP    = 4'd3;
  localparam logic [ADDR_W-1:0] A_UNBYP  = 4'd4;
  localparam logic [ADDR_W-1:0] A_UNCHG  = 4'd5;
  localparam logic [ADDR_W-1:0] A_SETTLE = 4'd6;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_FREEZE,
    ST_CHG,
    ST_BYP,
    ST_UNBYP,
    ST_UNCHG,
    ST_SETTLE
  } seq_state_t;

  function automatic int imax(int a, int b);
    return (a > b) ? a : b;
  endfunction
endpackage

// File: rtl/cfs_regs.sv
module cfs_regs
  import cfs_pkg::*;
#(
  parameter int CHG_W    = 8,
  parameter int BYP_W    = 16,
  parameter int UNBYP_W  = 8,
  parameter int UNCHG_W  = 8,
  parameter int SETTLE_W = 32
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                we,
  input  logic [ADDR_W-1:0]   addr,
  input  logic [DATA_W-1:0]   wdata,
  input  logic                busy,
  output logic [DATA_W-1:0]   rdata,
  output logic [CODE_W-1:0]   code_q,
  output logic [CHG_W-1:0]    chg_q,
  output logic [BYP_W-1:0]    byp_q,
  output logic [UNBYP_W-1:0]  unbyp_q,
  output logic [UNCHG_W-1:0]  unchg_q,
  output logic [SETTLE_W-1:0] settle_q
);
  logic en_code, en_chg, en_byp, en_unbyp, en_unchg, en_settle;
  logic [CODE_W-1:0] code_d;

  assign en_code   = we && (addr == A_CODE);
  assign en_chg    = we && (addr == A_CHG);
  assign en_byp    = we && (addr == A_BYP);
  assign en_unbyp  = we && (addr == A_UNBYP);
  assign en_unchg  = we && (addr == A_UNCHG);
  assign en_settle = we && (addr == A_SETTLE);

  assign code_d = wdata[CODE_W-1:0] & CODE_MASK;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      code_q <= '0;
    end else if (en_code) begin
      code_q <= code_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chg_q <= '0;
    end else if (en_chg) begin
      chg_q <= wdata[CHG_W-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      byp_q <= '0;
    end else if (en_byp) begin
      byp_q <= wdata[BYP_W-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      unbyp_q <= '0;
    end else if (en_unbyp) begin
      unbyp_q <= wdata[UNBYP_W-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      unchg_q <= '0;
    end else if (en_unchg) begin
      unchg_q <= wdata[UNCHG_W-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      settle_q <= '0;
    end else if (en_settle) begin
      settle_q <= wdata[SETTLE_W-1:0];
    end
  end

  always_comb begin
    rdata = '0;
    case (addr)
      A_CODE:   rdata = DATA_W'(code_q);
      A_STAT:   rdata = DATA_W'(busy);
      A_CHG:    rdata = DATA_W'(chg_q);
      A_BYP:    rdata = DATA_W'(byp_q);
      A_UNBYP:  rdata = DATA_W'(unbyp_q);
      A_UNCHG:  rdata = DATA_W'(unchg_q);
      A_SETTLE: rdata = DATA_W'(settle_q);
      default:  rdata = '0;
    endcase
  end
endmodule

// File: rtl/cfs_trig.sv
module cfs_trig
  import cfs_pkg::*;
(
  input  logic              we_code,
  input  logic [CODE_W-1:0] wcode,
  input  logic [CODE_W-1:0] code_q,
  input  logic              busy,
  output logic              fire,
  output logic [NLINE-1:0]  sel
);
  logic [CODE_W-1:0] new_v;
  logic [CODE_W-1:0] rise;
  logic              single;

  assign new_v  = wcode & CODE_MASK;
  assign rise   = new_v & ~code_q;
  assign single = $onehot(new_v);
  assign fire   = we_code && !busy && single && (rise == new_v);

  for (genvar i = 0; i < NLINE; i++) begin : g_line
    assign sel[i] = new_v[LINE_BIT[i]];
  end
endmodule

// File: rtl/cfs_seq.sv
module cfs_seq
  import cfs_pkg::*;
#(
  parameter int CHG_W    = 8,
  parameter int BYP_W    = 16,
  parameter int UNBYP_W  = 8,
  parameter int UNCHG_W  = 8,
  parameter int SETTLE_W = 32
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                fire,
  input  logic [NLINE-1:0]    sel_in,
  input  logic                freeze_ack,
  input  logic [CHG_W-1:0]    chg_dly,
  input  logic [BYP_W-1:0]    byp_dly,
  input  logic [UNBYP_W-1:0]  unbyp_dly,
  input  logic [UNCHG_W-1:0]  unchg_dly,
  input  logic [SETTLE_W-1:0] settle_dly,
  output logic                freeze_l,
  output logic [NLINE-1:0]    clk_change_l,
  output logic                pll_bypass,
  output logic                busy
);
  localparam int CNT_W = imax(imax(imax(CHG_W, BYP_W), imax(UNBYP_W, UNCHG_W)), SETTLE_W);

  seq_state_t        state_q, state_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic [NLINE-1:0]  sel_q, sel_d;
  logic              cnt_zero;
  logic              frz_l_d, byp_d;
  logic [NLINE-1:0]  chg_l_d;

  assign cnt_zero = (cnt_q == '0);

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    sel_d   = sel_q;
    case (state_q)
      ST_IDLE: begin
        if (fire) begin
          state_d = ST_FREEZE;
          sel_d   = sel_in;
        end
      end
      ST_FREEZE: begin
        if (freeze_ack) begin
          state_d = ST_CHG;
          cnt_d   = CNT_W'(chg_dly);
        end
      end
      ST_CHG: begin
        if (cnt_zero) begin
          state_d = ST_BYP;
          cnt_d   = CNT_W'(byp_dly);
        end else begin
          cnt_d = cnt_q - CNT_W'(1);
        end
      end
      ST_BYP: begin
        if (cnt_zero) begin
          state_d = ST_UNBYP;
          cnt_d   = CNT_W'(unbyp_dly);
        end else begin
          cnt_d = cnt_q - CNT_W'(1);
        end
      end
      ST_UNBYP: begin
        if (cnt_zero) begin
          state_d = ST_UNCHG;
          cnt_d   = CNT_W'(unchg_dly);
        end else begin
          cnt_d = cnt_q - CNT_W'(1);
        end
      end
      ST_UNCHG: begin
        if (cnt_zero) begin
          state_d = ST_SETTLE;
          cnt_d   = CNT_W'(settle_dly);
        end else begin
          cnt_d = cnt_q - CNT_W'(1);
        end
      end
      ST_SETTLE: begin
        if (cnt_zero) begin
          state_d = ST_IDLE;
        end else begin
          cnt_d = cnt_q - CNT_W'(1);
        end
      end
      default: begin
        state_d = ST_IDLE;
        cnt_d   = '0;
      end
    endcase
  end

  always_comb begin
    frz_l_d = (state_d == ST_IDLE);
    byp_d   = (state_d == ST_UNBYP);
    chg_l_d = (state_d inside {ST_BYP, ST_UNBYP, ST_UNCHG}) ? ~sel_d : '1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q      <= ST_IDLE;
      cnt_q        <= '0;
      sel_q        <= '0;
      freeze_l     <= 1'b1;
      clk_change_l <= '1;
      pll_bypass   <= 1'b0;
    end else begin
      state_q      <= state_d;
      cnt_q        <= cnt_d;
      sel_q        <= sel_d;
      freeze_l     <= frz_l_d;
      clk_change_l <= chg_l_d;
      pll_bypass   <= byp_d;
    end
  end

  assign busy = (state_q != ST_IDLE);
endmodule

// File: rtl/clk_freq_seq.sv
module clk_freq_seq
  import cfs_pkg::*;
#(
  parameter int CHG_W    = 8,
  parameter int BYP_W    = 16,
  parameter int UNBYP_W  = 8,
  parameter int UNCHG_W  = 8,
  parameter int SETTLE_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_we,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  input  logic              freeze_ack,
  output logic              freeze_l,
  output logic [NLINE-1:0]  clk_change_l,
  output logic              pll_bypass
);
  logic [1:0]          rst_sync;
  logic                srst_n;
  logic                busy_w;
  logic                fire_w;
  logic [NLINE-1:0]    sel_w;
  logic [CODE_W-1:0]   code_w;
  logic [CHG_W-1:0]    chg_w;
  logic [BYP_W-1:0]    byp_w;
  logic [UNBYP_W-1:0]  unbyp_w;
  logic [UNCHG_W-1:0]  unchg_w;
  logic [SETTLE_W-1:0] settle_w;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_sync <= 2'b00;
    end else begin
      rst_sync <= {rst_sync[0], 1'b1};
    end
  end
  assign srst_n = rst_sync[1];

  cfs_regs #(
    .CHG_W(CHG_W), .BYP_W(BYP_W), .UNBYP_W(UNBYP_W),
    .UNCHG_W(UNCHG_W), .SETTLE_W(SETTLE_W)
  ) u_regs (
    .clk(clk), .rst_n(srst_n), .we(reg_we), .addr(reg_addr),
    .wdata(reg_wdata), .busy(busy_w), .rdata(reg_rdata),
    .code_q(code_w), .chg_q(chg_w), .byp_q(byp_w),
    .unbyp_q(unbyp_w), .unchg_q(unchg_w), .settle_q(settle_w)
  );

  cfs_trig u_trig (
    .we_code(reg_we && (reg_addr == A_CODE)),
    .wcode(reg_wdata[CODE_W-1:0]),
    .code_q(code_w),
    .busy(busy_w),
    .fire(fire_w),
    .sel(sel_w)
  );

  cfs_seq #(
    .CHG_W(CHG_W), .BYP_W(BYP_W), .UNBYP_W(UNBYP_W),
    .UNCHG_W(UNCHG_W), .SETTLE_W(SETTLE_W)
  ) u_seq (
    .clk(clk), .rst_n(srst_n), .fire(fire_w), .sel_in(sel_w),
    .freeze_ack(freeze_ack), .chg_dly(chg_w), .byp_dly(byp_w),
    .unbyp_dly(unbyp_w), .unchg_dly(unchg_w), .settle_dly(settle_w),
    .freeze_l(freeze_l), .clk_change_l(clk_change_l),
    .pll_bypass(pll_bypass), .busy(busy_w)
  );
endmodule

// File: rtl/cfs_chk.sv
module cfs_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       freeze_l,
  input logic [2:0] clk_change_l,
  input logic       pll_bypass,
  input logic       busy
);
  // R2: at most one change line low
  p_one_line_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(~clk_change_l));

  // R2: the chosen line never switches inside a change window
  p_line_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ((clk_change_l != 3'b111) && ($past(clk_change_l) != 3'b111)) |-> $stable(clk_change_l));

  // R5: busy tracks the freeze request
  p_busy_freeze_r5: assert property (@(posedge clk) disable iff (!rst_n)
    busy == !freeze_l);

  // R6: change lines only move while frozen
  p_chg_frozen_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (clk_change_l != 3'b111) |-> !freeze_l);

  // R7: bypass only inside the change window
  p_byp_in_chg_r7: assert property (@(posedge clk) disable iff (!rst_n)
    pll_bypass |-> (clk_change_l != 3'b111));

  // R10: the freeze lifts only after lines and bypass are released
  p_clean_unfreeze_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(freeze_l) |-> ((clk_change_l == 3'b111) && !pll_bypass && ($past(clk_change_l) == 3'b111)));
endmodule

bind clk_freq_seq cfs_chk u_chk (
  .clk(clk),
  .rst_n(rst_n),
  .freeze_l(freeze_l),
  .clk_change_l(clk_change_l),
  .pll_bypass(pll_bypass),
  .busy(busy_w)
);

// File: tb/clk_freq_seq_tb_top.sv
module clk_freq_seq_tb_top;
  logic        clk;
  logic        rst_n;
  logic        reg_we;
  logic [3:0]  reg_addr;
  logic [31:0] reg_wdata;
  logic [31:0] reg_rdata;
  logic        freeze_ack;
  logic        freeze_l;
  logic [2:0]  clk_change_l;
  logic        pll_bypass;

  typedef struct {
    logic [4:0] val;
    int         cyc;
    string      req;
  } exp_t;

  exp_t exp_q[$];
  int   cyc;
  int   n_chk;
  int   n_fail;
  bit   mon_en;
  logic [4:0] prev;

  clk_freq_seq dut_i (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .freeze_ack(freeze_ack),
    .freeze_l(freeze_l), .clk_change_l(clk_change_l), .pll_bypass(pll_bypass)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  initial cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  // monitor: compares every output change against the scoreboard
  always @(negedge clk) begin
    logic [4:0] cur;
    exp_t e;
    #2;
    if (mon_en) begin
      cur = {freeze_l, clk_change_l, pll_bypass};
      if (cur !== prev) begin
        n_chk++;
        if (exp_q.size() == 0) begin
          n_fail++;
          $display("FAIL R11 unexpected output change: actual=%b@%0d expected=no change", cur, cyc);
        end else begin
          e = exp_q.pop_front();
          if (cur !== e.val || cyc != e.cyc) begin
            n_fail++;
            $display("FAIL %s: actual=%b@%0d expected=%b@%0d", e.req, cur, cyc, e.val, e.cyc);
          end
        end
        prev = cur;
      end
    end
  end

  always @(posedge clk) begin
    if (cyc == 60000) begin
      n_chk++;
      n_fail++;
      $display("FAIL R10 watchdog: actual=%0d cycles expected=finish earlier", cyc);
      $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
    end
  end

  task automatic push(input logic [4:0] v, input int c, input string r);
    exp_t e;
    e.val = v; e.cyc = c; e.req = r;
    exp_q.push_back(e);
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_addr = a;
    #1;
    d = reg_rdata;
  endtask

  task automatic idle_check(input string req, input int n);
    logic [31:0] d;
    repeat (n) @(negedge clk);
    rd(4'd1, d);
    chk(req, d, 32'd0);
    chk(req, {27'd0, freeze_l, clk_change_l, pll_bypass}, {27'd0, 5'b11110});
  endtask

  task automatic run_seq(input logic [7:0] code, input logic [2:0] line,
                         input int c, input int b, input int u, input int uc, input int s,
                         input int ack_gap, input bit poke, input logic [7:0] poke_code);
    int w, a, t1, t2, t3, t4, t5;
    logic [31:0] d;
    wr(4'd2, c); wr(4'd3, b); wr(4'd4, u); wr(4'd5, uc); wr(4'd6, s);
    @(negedge clk);
    w = cyc + 1;
    push({1'b0, 3'b111, 1'b0}, w, "R5");
    reg_we = 1'b1; reg_addr = 4'd0; reg_wdata = {24'd0, code};
    @(negedge clk);
    reg_we = 1'b0;
    repeat (ack_gap) @(negedge clk);
    if (poke) begin
      wr(4'd0, 32'd0);
      wr(4'd0, {24'd0, poke_code});
      rd(4'd1, d);
      chk("R11", d, 32'd1);
    end
    @(negedge clk);
    a = cyc + 1;
    freeze_ack = 1'b1;
    t1 = a + c + 1;
    t2 = t1 + b + 1;
    t3 = t2 + u + 1;
    t4 = t3 + uc + 1;
    t5 = t4 + s + 1;
    push({1'b0, ~line, 1'b0}, t1, "R6");
    push({1'b0, ~line, 1'b1}, t2, "R7");
    push({1'b0, ~line, 1'b0}, t3, "R8");
    push({1'b0, 3'b111, 1'b0}, t4, "R9");
    push({1'b1, 3'b111, 1'b0}, t5, "R10");
    while (cyc < t5 - 1) @(negedge clk);
    reg_addr = 4'd1; #1;
    chk("R11", reg_rdata, 32'd1);
    while (cyc < t5 + 1) @(negedge clk);
    freeze_ack = 1'b0;
    reg_addr = 4'd1; #1;
    chk("R10", reg_rdata, 32'd0);
  endtask

  initial begin
    logic [31:0] d;
    n_chk = 0; n_fail = 0; mon_en = 1'b0;
    rst_n = 1'b0; reg_we = 1'b0; reg_addr = '0; reg_wdata = '0; freeze_ack = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    chk("R1", {29'd0, freeze_l, pll_bypass, 1'b0}, {29'd0, 1'b1, 1'b0, 1'b0});
    chk("R1", {29'd0, clk_change_l}, 32'd7);
    for (int i = 0; i < 7; i++) begin
      rd(i[3:0], d);
      chk("R1", d, 32'd0);
    end
    prev = {freeze_l, clk_change_l, pll_bypass};
    mon_en = 1'b1;

    // R12 register readback and truncation
    wr(4'd2, 32'h0000_01A5); rd(4'd2, d); chk("R12", d, 32'h0000_00A5);
    wr(4'd3, 32'h0001_2345); rd(4'd3, d); chk("R12", d, 32'h0000_2345);
    wr(4'd4, 32'hFFFF_FF3C); rd(4'd4, d); chk("R12", d, 32'h0000_003C);
    wr(4'd5, 32'h0000_0177); rd(4'd5, d); chk("R12", d, 32'h0000_0077);
    wr(4'd6, 32'hDEAD_BEEF); rd(4'd6, d); chk("R12", d, 32'hDEAD_BEEF);

    // R3 reserved-only code: dropped, no action
    wr(4'd0, 32'h0000_00DC); rd(4'd0, d); chk("R3", d, 32'd0);
    idle_check("R3", 4);
    // R3 several valid bits: no action
    wr(4'd0, 32'h0000_0023); rd(4'd0, d); chk("R3", d, 32'h23);
    idle_check("R3", 4);
    wr(4'd0, 32'h0000_0003);
    idle_check("R3", 4);
    wr(4'd0, 32'd0);

    // R2 full speed, with held-back ack and writes while busy (R11)
    run_seq(8'h01, 3'b001, 2, 3, 1, 4, 5, 3, 1'b1, 8'h02);
    // R4 stored code is 0x02 now; same code again does nothing
    wr(4'd0, 32'h0000_0002);
    idle_check("R4", 6);
    wr(4'd0, 32'd0);

    // R2 half speed, all delays zero
    run_seq(8'h02, 3'b010, 0, 0, 0, 0, 0, 0, 1'b0, 8'h00);
    // R4 repeat without clearing
    wr(4'd0, 32'h0000_0002);
    idle_check("R4", 5);
    wr(4'd0, 32'd0);

    // R2 1/32 speed with a long settle and a reserved bit mixed in (R3)
    run_seq(8'h24, 3'b100, 7, 10, 3, 2, 40, 5, 1'b0, 8'h00);
    rd(4'd0, d); chk("R3", d, 32'h20);
    // R3 direct change to a new single bit without clearing starts a sequence
    run_seq(8'h01, 3'b001, 1, 2, 0, 1, 3, 1, 1'b0, 8'h00);

    repeat (10) @(negedge clk);
    chk("R10", exp_q.size(), 32'd0);
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule